// File: doc/BRIEF.md
# UART FIFO Fill-Level Readback

This block sits on the byte-wide host bus of a UART. It lets software read the fill levels of the receive and transmit FIFOs through the address that normally holds a general-purpose scratch byte. A feature-control register gates the function. While its bit 6 is 0, the scratch address is ordinary read/write storage. While bit 6 is 1, a host write to the scratch address loads a write-only count-mode register, and a host read of it returns a FIFO count.

The count-mode register has three active bits. One picks the transmit count over the receive count. One makes successive reads alternate between the two counts. One chooses which direction the DMA logic serves. A status bit in the trigger register tells software whether the last count it read came from the receive side or the transmit side. This matters most in alternating mode.

Top module: `uart_fifo_cnt_rb`

## Requirements
- R1: After reset the feature register (address 2) reads 0x00, the scratch address (address 7) reads 0xFF, the trigger register (address 1) reads 0x00, and `dma_rx_en`=1 with `dma_tx_en`=0.
- R2: While feature bit 6 is 0, a write to address 7 stores the byte and a later read returns it. Every host read returns its data on `rd_data` one clock after the cycle in which `rd_en` is sampled.
- R3: While feature bit 6 is 1, a write to address 7 loads the count-mode register and leaves the stored scratch byte unchanged. A read of address 7 never returns the count-mode register contents.
- R4: With count-mode bit 0 = 0, a read of address 7 returns `rx_cnt`, and trigger bit 7 then reads 0.
- R5: With count-mode bit 0 = 1 and bit 1 = 0, a read of address 7 returns `tx_cnt`, and trigger bit 7 reads 1. Trigger bits 6:0 always read 0.
- R6: With count-mode bits 0 and 1 both 1, reads of address 7 alternate between receive and transmit counts, starting with receive after every count-mode write. Trigger bit 7 gives the source of the most recent count read (0 receive, 1 transmit). Reads of other addresses do not advance the alternation.
- R7: Count-mode bit 2 selects DMA direction: 0 gives `dma_rx_en`=1 and `dma_tx_en`=0, 1 gives the reverse. Exactly one is high, and a change is visible the cycle after the write.
- R8: Count-mode bits 7:3 have no effect on any output.
- R9: Counts from 0 to 128 are returned unchanged, including both limits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Host register address |
| wr_en | input | 1 | Host write strobe, one cycle per write |
| rd_en | input | 1 | Host read strobe, one cycle per read |
| wr_data | input | 8 | Host write data |
| rd_data | output | 8 | Host read data, registered |
| rx_cnt | input | 8 | Receive FIFO fill level |
| tx_cnt | input | 8 | Transmit FIFO fill level |
| dma_rx_en | output | 1 | DMA serves the receive direction |
| dma_tx_en | output | 1 | DMA serves the transmit direction |

## Verification
Read data is due one clock after the read strobe is sampled. The trigger status bit and the DMA selects change on the edge that samples the read or write causing the change, so they are visible from the next cycle.

The bench drives strobes on falling edges. At each read strobe it queues the expected byte, and a monitor compares `rd_data` on the next falling edge after the capturing rising edge. DMA outputs are sampled on the falling edge after the write's capturing edge. A status read always follows a count read with at least one cycle between them, so it sees the updated flag.

// File: rtl/ufc_pkg.sv
package ufc_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] ADR_TRG  = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_FEAT = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_SCR  = 3'd7;
  localparam int FEAT_CNT_BIT = 6;
  localparam int TRG_SRC_BIT  = 7;
  localparam logic [DATA_W-1:0] SCR_RST = '1;

  typedef enum logic {SRC_RX = 1'b0, SRC_TX = 1'b1} src_e;

  typedef struct packed {
    logic dma_tx;
    logic alt;
    logic tx_sel;
  } mode_t;

  // Only the low three bits carry meaning; the rest are dropped here.
  function automatic mode_t decode_mode(input logic [DATA_W-1:0] b);
    mode_t m;
    m.dma_tx = b[2];
    m.alt    = b[1];
    m.tx_sel = b[0];
    return m;
  endfunction

  function automatic logic alt_on(input mode_t m);
    return m.tx_sel && m.alt;
  endfunction

  function automatic src_e pick_src(input mode_t m, input logic phase);
    if (alt_on(m)) begin
      if (phase) return SRC_TX;
      return SRC_RX;
    end
    if (m.tx_sel) return SRC_TX;
    return SRC_RX;
  endfunction

  function automatic logic [DATA_W-1:0] status_byte(input src_e s);
    logic [DATA_W-1:0] b;
    b = '0;
    b[TRG_SRC_BIT] = (s == SRC_TX);
    return b;
  endfunction
endpackage

// File: rtl/ufc_regs.sv
module ufc_regs
  import ufc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] feat_q,
  output logic [DATA_W-1:0] scr_q,
  output mode_t             mode_q,
  output logic              mode_wr,
  output logic              cnt_en
);
  logic scr_hit;
  logic scr_wr;
  logic feat_wr;

  assign cnt_en  = feat_q[FEAT_CNT_BIT];
  assign scr_hit = wr_en && (addr == ADR_SCR);
  assign mode_wr = scr_hit && cnt_en;
  assign scr_wr  = scr_hit && !cnt_en;
  assign feat_wr = wr_en && (addr == ADR_FEAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      feat_q <= '0;
      scr_q  <= SCR_RST;
      mode_q <= '0;
    end else begin
      if (feat_wr) feat_q <= wr_data;
      if (scr_wr)  scr_q  <= wr_data;
      if (mode_wr) mode_q <= decode_mode(wr_data);
    end
  end

  AST_SCRATCH_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> $stable(scr_q)); // R3
  AST_RSV_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> (mode_q == decode_mode($past(wr_data) & 8'h07))); // R8
endmodule

// File: rtl/ufc_seq.sv
module ufc_seq
  import ufc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  mode_t mode_q,
  input  mode_t mode_nxt,
  input  logic  mode_wr,
  input  logic  cnt_rd,
  output src_e  src_used,
  output src_e  last_src
);
  logic alt_phase;
  logic adv;

  assign src_used = pick_src(mode_q, alt_phase);
  assign adv      = cnt_rd && alt_on(mode_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alt_phase <= 1'b0;
      last_src  <= SRC_RX;
    end else if (mode_wr) begin
      alt_phase <= 1'b0;
      last_src  <= pick_src(mode_nxt, 1'b0);
    end else begin
      if (adv)    alt_phase <= !alt_phase;
      if (cnt_rd) last_src  <= src_used;
    end
  end

  AST_ALT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> !alt_phase); // R6
  AST_ALT_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !mode_wr) |=> (alt_phase != $past(alt_phase))); // R6
  AST_ALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_rd && !mode_wr) |=> $stable(alt_phase)); // R6
endmodule

// File: rtl/ufc_rdmux.sv
module ufc_rdmux
  import ufc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              cnt_en,
  input  logic [DATA_W-1:0] feat_q,
  input  logic [DATA_W-1:0] scr_q,
  input  src_e              src_used,
  input  src_e              last_src,
  input  logic [CNT_W-1:0]  rx_cnt,
  input  logic [CNT_W-1:0]  tx_cnt,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] cnt_byte;
  logic [DATA_W-1:0] rd_nxt;

  assign cnt_byte = (src_used == SRC_TX) ? DATA_W'(tx_cnt) : DATA_W'(rx_cnt);

  always_comb begin
    rd_nxt = '0;
    case (addr)
      ADR_SCR:  rd_nxt = cnt_en ? cnt_byte : scr_q;
      ADR_FEAT: rd_nxt = feat_q;
      ADR_TRG:  rd_nxt = status_byte(last_src);
      default:  rd_nxt = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_nxt;
  end

  AST_RX_RETURNED: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == ADR_SCR && cnt_en && src_used == SRC_RX)
      |=> (rd_data == DATA_W'($past(rx_cnt)))); // R4
  AST_TX_RETURNED: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == ADR_SCR && cnt_en && src_used == SRC_TX)
      |=> (rd_data == DATA_W'($past(tx_cnt)))); // R5
endmodule

// File: rtl/uart_fifo_cnt_rb.sv
module uart_fifo_cnt_rb
  import ufc_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int FIFO_DEPTH = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic [CNT_W-1:0]  rx_cnt,
  input  logic [CNT_W-1:0]  tx_cnt,
  output logic              dma_rx_en,
  output logic              dma_tx_en
);
  localparam logic [CNT_W-1:0] DEPTH_V = CNT_W'(FIFO_DEPTH);

  logic [DATA_W-1:0] feat_q;
  logic [DATA_W-1:0] scr_q;
  mode_t             mode_q;
  mode_t             mode_nxt;
  logic              mode_wr;
  logic              cnt_en;
  logic              cnt_rd;
  src_e              src_used;
  src_e              last_src;

  assign mode_nxt  = decode_mode(wr_data);
  assign cnt_rd    = rd_en && (addr == ADR_SCR) && cnt_en;
  assign dma_tx_en = mode_q.dma_tx;
  assign dma_rx_en = !mode_q.dma_tx;

  ufc_regs u_regs (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .feat_q(feat_q), .scr_q(scr_q), .mode_q(mode_q), .mode_wr(mode_wr),
    .cnt_en(cnt_en)
  );

  ufc_seq u_seq (
    .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .mode_nxt(mode_nxt),
    .mode_wr(mode_wr), .cnt_rd(cnt_rd), .src_used(src_used), .last_src(last_src)
  );

  ufc_rdmux #(.CNT_W(CNT_W)) u_rdmux (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr), .cnt_en(cnt_en),
    .feat_q(feat_q), .scr_q(scr_q), .src_used(src_used), .last_src(last_src),
    .rx_cnt(rx_cnt), .tx_cnt(tx_cnt), .rd_data(rd_data)
  );

  AST_DMA_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> (dma_tx_en == $past(wr_data[2]) && dma_rx_en == !$past(wr_data[2]))); // R7
  AST_DMA_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_wr |=> ($stable(dma_tx_en) && $stable(dma_rx_en))); // R7
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt <= DEPTH_V) && (tx_cnt <= DEPTH_V)); // R9
endmodule

// File: tb/uart_fifo_cnt_rb_tb.sv
module uart_fifo_cnt_rb_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [7:0] rx_cnt = '0;
  logic [7:0] tx_cnt = '0;
  logic       dma_rx_en;
  logic       dma_tx_en;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_seen = 1'b0;

  always #10 clk = !clk;

  uart_fifo_cnt_rb dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wr_data(wr_data), .rd_data(rd_data), .rx_cnt(rx_cnt), .tx_cnt(tx_cnt),
    .dma_rx_en(dma_rx_en), .dma_tx_en(dma_tx_en)
  );

  // Monitor: rd_data is due on the falling edge after the capturing rising edge.
  always @(posedge clk) rd_seen <= rd_en;
  always @(negedge clk) begin
    if (rd_seen) begin
      logic [7:0] e;
      string t;
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL scoreboard: unexpected read data act=%02h exp=none", rd_data);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rd_data !== e) begin
          errors++;
          $display("FAIL %s: act=%02h exp=%02h", t, rd_data, e);
        end
      end
    end
  end

  task automatic host_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic host_rd(input logic [2:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    exp_q.push_back(e);
    tag_q.push_back(t);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic chk_dma(input logic exp_tx, input string t);
    checks++;
    if (dma_tx_en !== exp_tx || dma_rx_en !== !exp_tx) begin
      errors++;
      $display("FAIL %s: act rx/tx=%b%b exp=%b%b", t, dma_rx_en, dma_tx_en, !exp_tx, exp_tx);
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: act=timeout exp=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_dma(1'b0, "R1 reset dma");
    host_rd(3'd2, 8'h00, "R1 feature reset");
    host_rd(3'd7, 8'hFF, "R1 scratch reset");
    host_rd(3'd1, 8'h00, "R1 trigger reset");

    host_wr(3'd7, 8'h5A);
    host_rd(3'd7, 8'h5A, "R2 scratch store");
    host_wr(3'd7, 8'hA5);
    host_rd(3'd7, 8'hA5, "R2 scratch store 2");

    host_wr(3'd2, 8'h40);
    host_rd(3'd2, 8'h40, "R2 feature readback");
    rx_cnt = 8'd17; tx_cnt = 8'd99;

    host_wr(3'd7, 8'h00);
    host_rd(3'd7, 8'd17, "R4 rx count");
    host_rd(3'd1, 8'h00, "R4 status rx");

    host_wr(3'd7, 8'h01);
    host_rd(3'd7, 8'd99, "R5 tx count, R3 mode not readable");
    host_rd(3'd1, 8'h80, "R5 status tx");

    host_wr(3'd7, 8'h03);
    host_rd(3'd7, 8'd17, "R6 alt first rx");
    host_rd(3'd1, 8'h00, "R6 status after rx");
    host_rd(3'd7, 8'd99, "R6 alt tx");
    host_rd(3'd1, 8'h80, "R6 status after tx");
    host_rd(3'd7, 8'd17, "R6 alt rx again");
    host_wr(3'd7, 8'h03);
    host_rd(3'd7, 8'd17, "R6 restart after mode write");
    host_rd(3'd7, 8'd99, "R6 tx after restart");

    host_wr(3'd7, 8'hF9);
    host_rd(3'd7, 8'd99, "R8 reserved bits with tx");
    chk_dma(1'b0, "R8 reserved bits dma");
    host_wr(3'd7, 8'hFB);
    host_rd(3'd7, 8'd17, "R8 reserved bits alt rx");
    host_rd(3'd7, 8'd99, "R8 reserved bits alt tx");

    host_wr(3'd7, 8'h04);
    chk_dma(1'b1, "R7 dma tx select");
    host_rd(3'd7, 8'd17, "R7 dma bit leaves rx count");
    host_wr(3'd7, 8'hFC);
    chk_dma(1'b1, "R7 dma tx with reserved");
    host_wr(3'd7, 8'h00);
    chk_dma(1'b0, "R7 dma rx select");

    rx_cnt = 8'd0; tx_cnt = 8'd128;
    host_wr(3'd7, 8'h01);
    host_rd(3'd7, 8'd128, "R9 full tx count");
    host_wr(3'd7, 8'h00);
    host_rd(3'd7, 8'd0, "R9 empty rx count");
    rx_cnt = 8'd128; tx_cnt = 8'd0;
    host_rd(3'd7, 8'd128, "R9 full rx count");

    host_wr(3'd2, 8'h00);
    host_rd(3'd7, 8'hA5, "R3 scratch kept across mode writes");

    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R2 read latency: act pending=%0d exp=0", exp_q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule